// File: doc/BRIEF.md
# Serial Port Loopback Routing Matrix

This block is the digital routing fabric of a serial-port test fixture. It decides what drives three inputs of the unit under test: its clock input, its data input and its audio input. The clock input is driven either by the fixture's baud clock or by the unit's own clock output. The data input is driven either by the fixture's pattern stream or by the unit's own data output.

The audio input is normally held quiet. It carries the selected clock only when its control bit asks for it and the unit's motor-control line is high. Two more lines are fixed loopbacks. The unit's command output goes to its interrupt input, and its motor-control output goes to its proceed input.

Test software on the unit sets the three control bits, runs a transfer and judges the result. The block keeps no state. Every output follows the present inputs with only gate delay.

Top module: `lbr_route_matrix`

## Requirements
- R1: With route control bit 0 at 0, the clock-in output equals the baud clock input.
- R2: With route control bit 0 at 1, the clock-in output equals the unit's clock-out input.
- R3: Route control bit 1 picks the data-in source. At 0 it is the pattern stream and at 1 the unit's data-out.
- R4: When route control bit 2 is 1 and motor-control is high, the audio output equals the clock-in output and the audio enable output is 1.
- R5: When route control bit 2 is 0 or motor-control is low, the audio output is 0 and the audio enable output is 0.
- R6: The interrupt output always equals the command input.
- R7: The proceed output always equals the motor-control input.
- R8: Each route control bit affects only its own path. Bit 0 never changes data-in, bit 1 never changes clock-in or audio, and bit 2 changes neither clock-in nor data-in.
- R9: The outputs depend only on the present inputs. The same inputs give the same outputs whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| route_sel_i | input | 3 | Route control: bit 0 clock source, bit 1 data source, bit 2 audio request (0 = generator / quiet, 1 = loopback / audio) |
| baud_clk_i | input | 1 | Baud clock from the fixture generator |
| pat_data_i | input | 1 | Serial pattern stream from the fixture |
| uut_clk_out_i | input | 1 | Clock output of the unit under test |
| uut_data_out_i | input | 1 | Data output of the unit under test |
| uut_cmd_i | input | 1 | Command output of the unit under test |
| uut_motor_i | input | 1 | Motor-control output of the unit under test |
| uut_clk_in_o | output | 1 | Drives the unit's clock input |
| uut_data_in_o | output | 1 | Drives the unit's data input |
| uut_audio_o | output | 1 | Drives the unit's audio input (0 when quiet) |
| audio_en_o | output | 1 | 1 while the audio input is connected |
| uut_irq_o | output | 1 | Drives the unit's interrupt input |
| uut_proceed_o | output | 1 | Drives the unit's proceed input |

## Verification
The hardest situation to reach is the audio route. It needs the request bit and motor-control high together, and its value also depends on which clock source bit 0 has picked. The bench therefore sweeps all combinations of the three control bits and the six signal inputs. That sweep puts the audio path on both clock sources with each source both high and low, and it also catches an audio path that ignores the motor gate.

Separate scenarios toggle one control bit while holding everything else. These check that the other paths stay unchanged. A replay of earlier input vectors after different histories checks that no hidden state exists.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned SEL_CLK = 0;
    localparam int unsigned SEL_DAT = 1;
    localparam int unsigned SEL_AUD = 2;

    typedef enum logic {
        SRC_GEN  = 1'b0,
        SRC_LOOP = 1'b1
    } src_e;

    typedef struct packed {
        logic clk_in;
        logic data_in;
        logic audio;
        logic audio_en;
        logic irq;
        logic proceed;
    } route_out_t;

endpackage

// File: rtl/lbr_path_sel.sv
module lbr_path_sel #(
    parameter int unsigned W = 1
) (
    input  lbr_pkg::src_e  src_i,
    input  logic [W-1:0]   gen_i,
    input  logic [W-1:0]   loop_i,
    output logic [W-1:0]   out_o
);
    import lbr_pkg::*;

    logic [W-1:0] out_d;

    always_comb begin
        out_d = gen_i;
        if (src_i == SRC_LOOP) begin
            out_d = loop_i;
        end
    end

    assign out_o = out_d;

endmodule

// File: rtl/lbr_audio_gate.sv
module lbr_audio_gate #(
    parameter int unsigned W = 1
) (
    input  logic          req_i,
    input  logic          motor_i,
    input  logic [W-1:0]  clk_sel_i,
    output logic [W-1:0]  audio_o,
    output logic          en_o
);
    logic          en_d;
    logic [W-1:0]  audio_d;

    always_comb begin
        en_d    = req_i & motor_i;
        audio_d = '0;
        if (en_d) begin
            audio_d = clk_sel_i;
        end
    end

    assign en_o    = en_d;
    assign audio_o = audio_d;

    // R5: a quiet audio line carries no signal
    always_comb begin
        if (!en_o) begin
            a_r5_quiet_is_zero: assert (audio_o == '0)
                else $error("audio driven while disconnected");
        end
    end

    // R5: the enable never rises without the motor line
    always_comb begin
        if (!motor_i) begin
            a_r5_motor_gates: assert (!en_o)
                else $error("audio enabled with motor low");
        end
    end

endmodule

// File: rtl/lbr_route_matrix.sv
module lbr_route_matrix
    import lbr_pkg::*;
#(
    parameter int unsigned W = 1
) (
    input  logic [SEL_W-1:0] route_sel_i,
    input  logic             baud_clk_i,
    input  logic             pat_data_i,
    input  logic             uut_clk_out_i,
    input  logic             uut_data_out_i,
    input  logic             uut_cmd_i,
    input  logic             uut_motor_i,
    output logic             uut_clk_in_o,
    output logic             uut_data_in_o,
    output logic             uut_audio_o,
    output logic             audio_en_o,
    output logic             uut_irq_o,
    output logic             uut_proceed_o
);

    localparam int unsigned N_PATHS = 2;

    logic [N_PATHS-1:0] gen_v;
    logic [N_PATHS-1:0] loop_v;
    logic [N_PATHS-1:0] path_v;
    src_e               src_v [N_PATHS];
    logic               audio_w;
    logic               aud_en_w;
    route_out_t         out_d;

    always_comb begin
        gen_v[SEL_CLK]  = baud_clk_i;
        gen_v[SEL_DAT]  = pat_data_i;
        loop_v[SEL_CLK] = uut_clk_out_i;
        loop_v[SEL_DAT] = uut_data_out_i;
    end

    for (genvar g = 0; g < N_PATHS; g++) begin : g_path
        assign src_v[g] = src_e'(route_sel_i[g]);
        lbr_path_sel #(.W(1)) u_sel (
            .src_i  (src_v[g]),
            .gen_i  (gen_v[g]),
            .loop_i (loop_v[g]),
            .out_o  (path_v[g])
        );
    end

    lbr_audio_gate #(.W(1)) u_aud (
        .req_i     (route_sel_i[SEL_AUD]),
        .motor_i   (uut_motor_i),
        .clk_sel_i (path_v[SEL_CLK]),
        .audio_o   (audio_w),
        .en_o      (aud_en_w)
    );

    always_comb begin
        out_d          = '0;
        out_d.clk_in   = path_v[SEL_CLK];
        out_d.data_in  = path_v[SEL_DAT];
        out_d.audio    = audio_w;
        out_d.audio_en = aud_en_w;
        out_d.irq      = uut_cmd_i;
        out_d.proceed  = uut_motor_i;
    end

    assign uut_clk_in_o  = out_d.clk_in;
    assign uut_data_in_o = out_d.data_in;
    assign uut_audio_o   = out_d.audio;
    assign audio_en_o    = out_d.audio_en;
    assign uut_irq_o     = out_d.irq;
    assign uut_proceed_o = out_d.proceed;

    // R4: a connected audio line mirrors the selected clock
    always_comb begin
        if (audio_en_o) begin
            a_r4_audio_tracks_clk: assert (uut_audio_o == uut_clk_in_o)
                else $error("audio differs from clock-in");
        end
    end

    // R1 / R2: clock-in always comes from one of its two sources
    always_comb begin
        a_r1_clk_from_source: assert ((uut_clk_in_o == baud_clk_i) ||
                                      (uut_clk_in_o == uut_clk_out_i))
            else $error("clock-in from no source");
    end

    // R3: data-in always comes from one of its two sources
    always_comb begin
        a_r3_data_from_source: assert ((uut_data_in_o == pat_data_i) ||
                                       (uut_data_in_o == uut_data_out_i))
            else $error("data-in from no source");
    end

    // R7: proceed never disagrees with an enabled audio request
    always_comb begin
        if (audio_en_o) begin
            a_r7_proceed_with_audio: assert (uut_proceed_o)
                else $error("audio enabled while proceed low");
        end
    end

endmodule

// File: tb/sim_lbr_route_matrix.sv
module sim_lbr_route_matrix;

    localparam time TCLK = 10ns;

    logic       clk = 1'b0;
    logic [2:0] sel;
    logic       baud, pat, cko, dto, cmd, mot;
    logic       ckin, dtin, aud, aen, irq, prc;

    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #(TCLK/2) clk = ~clk;

    lbr_route_matrix u0 (
        .route_sel_i    (sel),
        .baud_clk_i     (baud),
        .pat_data_i     (pat),
        .uut_clk_out_i  (cko),
        .uut_data_out_i (dto),
        .uut_cmd_i      (cmd),
        .uut_motor_i    (mot),
        .uut_clk_in_o   (ckin),
        .uut_data_in_o  (dtin),
        .uut_audio_o    (aud),
        .audio_en_o     (aen),
        .uut_irq_o      (irq),
        .uut_proceed_o  (prc)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b sel=%b in=%b%b%b%b%b%b",
                     req, what, act, exp, sel, baud, pat, cko, dto, cmd, mot);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        @(negedge clk);
        {sel, baud, pat, cko, dto, cmd, mot} = v;
        #1;
    endtask

    // full model check of one vector, all requirements
    task automatic check_all();
        logic ec, ed, ea, ee;
        ec = sel[0] ? cko : baud;
        ed = sel[1] ? dto : pat;
        ee = sel[2] & mot;
        ea = ee ? ec : 1'b0;
        chk(sel[0] ? "R2" : "R1", "clk_in", ckin, ec);
        chk("R3", "data_in", dtin, ed);
        chk(ee ? "R4" : "R5", "audio", aud, ea);
        chk(ee ? "R4" : "R5", "audio_en", aen, ee);
        chk("R6", "irq", irq, cmd);
        chk("R7", "proceed", prc, mot);
    endtask

    task automatic t_idle();
        drive(9'd0);
        chk("R1", "idle clk_in", ckin, 1'b0);
        chk("R5", "idle audio_en", aen, 1'b0);
        chk("R6", "idle irq", irq, 1'b0);
    endtask

    task automatic t_sweep();
        for (int v = 0; v < 512; v++) begin
            drive(v[8:0]);
            check_all();
        end
    endtask

    task automatic t_isolation();
        logic d0, c0, a0;
        // R8: bit 0 leaves data-in alone
        drive({3'b100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
        d0 = dtin;
        drive({3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
        chk("R8", "bit0 vs data_in", dtin, d0);
        // R8: bit 1 leaves clock-in and audio alone
        c0 = ckin; a0 = aud;
        drive({3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
        chk("R8", "bit1 vs clk_in", ckin, c0);
        chk("R8", "bit1 vs audio", aud, a0);
        // R8: bit 2 leaves clock-in and data-in alone
        c0 = ckin; d0 = dtin;
        drive({3'b011, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1});
        chk("R8", "bit2 vs clk_in", ckin, c0);
        chk("R8", "bit2 vs data_in", dtin, d0);
        chk("R5", "bit2 low audio", aud, 1'b0);
    endtask

    task automatic t_motor_gate();
        // R4/R5: audio request held, motor toggled, looped clock high
        drive({3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1});
        chk("R4", "motor high audio", aud, 1'b1);
        chk("R4", "motor high en", aen, 1'b1);
        drive({3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0});
        chk("R5", "motor low audio", aud, 1'b0);
        chk("R5", "motor low en", aen, 1'b0);
        chk("R7", "motor low proceed", prc, 1'b0);
    endtask

    task automatic t_no_state();
        logic [5:0] first;
        logic [8:0] probe = 9'b101_1010_01;
        drive(probe);
        first = {ckin, dtin, aud, aen, irq, prc};
        drive(9'h1FF);
        drive(9'h000);
        drive(probe);
        chk("R9", "replay clk_in", ckin, first[5]);
        chk("R9", "replay data_in", dtin, first[4]);
        chk("R9", "replay audio", aud, first[3]);
        chk("R9", "replay proceed", prc, first[0]);
    endtask

    initial begin
        sel = '0; baud = 0; pat = 0; cko = 0; dto = 0; cmd = 0; mot = 0;
        t_idle();
        t_sweep();
        t_isolation();
        t_motor_gate();
        t_no_state();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule